// File: doc/BRIEF.md
# Receive Read Timeout Timer

This block watches a receive queue for characters that nobody collects. It loads a 16-bit down-counter from a programmable timeout value. The counter steps down once for every enabled smart card clock, but only while the queue holds at least one character and no read is under way. When the count runs out, a level interrupt goes high. The interrupt stays high until software clears it or reads a character from the queue.

The timeout value has a write strobe. A value of zero is not allowed: the block drops such a write and keeps the old value. A non-zero write made while the counter is running loads the new value into the counter straight away, and counting carries on down from there. A read from the queue, or an empty queue, reloads the counter from the stored value.

Top module: `rx_read_timeout`

## Requirements
- R1: Under reset, `rtout` is low and the stored timeout equals the parameter `RESET_LIMIT` (default 200). After reset, with the queue non-empty and the clock enable held high, `rtout` rises `RESET_LIMIT` cycles later.
- R2: With a stored value N, the queue non-empty and no read, `rtout` becomes visible high in the cycle after the N-th clock edge that sees `card_clk_en` high.
- R3: A cycle with `card_clk_en` low does not advance the count.
- R4: A cycle with `rx_rd` high reloads the counter from the stored value and clears `rtout`.
- R5: While `rx_not_empty` is low, the counter is held at the stored value and `rtout` never rises.
- R6: A write with a non-zero value sets the stored value for later reloads. If the queue is non-empty and not being read, the same write also loads the counter, even in the middle of a count or after it has run out.
- R7: A write of zero changes neither the stored value nor the count in progress.
- R8: Once high, `rtout` stays high until `irq_clr` or `rx_rd` is seen. If a clear and an expiry fall in the same cycle, `rtout` stays high.
- R9: A run-out raises `rtout` only once. After it is cleared, `rtout` stays low until the counter has been reloaded or loaded by a write and has run out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_wr | input | 1 | Write strobe for the timeout value |
| tmo_wdata | input | 16 | Timeout value in card clocks (zero is dropped) |
| rx_not_empty | input | 1 | Receive queue holds at least one character |
| rx_rd | input | 1 | Receive queue read strobe |
| card_clk_en | input | 1 | One-cycle pulse per smart card clock |
| irq_clr | input | 1 | Clears the interrupt |
| rtout | output | 1 | Receive timeout interrupt (level) |

## Verification
Each input is sampled at a clock edge, and its effect shows on `rtout` one edge later. An expiry on the N-th enabled edge is therefore visible just after that edge, and a read or clear drops the interrupt after the edge that sees it. The bench drives inputs on falling edges and compares `rtout` with its queue-free integer model at every falling edge, i.e. half a cycle after the edge that should have changed it. Directed checks are placed after counted cycles, so that the output is sampled exactly one enabled edge before and on the cycle where it is due.

// File: rtl/rx_read_timeout_pkg.sv
package rx_read_timeout_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_RELOAD = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_DEC    = 2'd3
  } cnt_act_e;

  // Chooses what the down-counter does this cycle.
  function automatic cnt_act_e pick_action(input logic not_empty,
                                           input logic rd,
                                           input logic wr_ok,
                                           input logic tick,
                                           input logic cnt_zero);
    cnt_act_e a;
    if (!not_empty || rd)      a = ACT_RELOAD;
    else if (wr_ok)            a = ACT_LOAD;
    else if (tick && !cnt_zero) a = ACT_DEC;
    else                       a = ACT_HOLD;
    return a;
  endfunction

  // Interrupt flag update: a new expiry wins over a clear.
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr);
    logic n;
    if (set)      n = 1'b1;
    else if (clr) n = 1'b0;
    else          n = q;
    return n;
  endfunction

endpackage

// File: rtl/rtmo_limit_reg.sv
module rtmo_limit_reg #(
  parameter int          W         = 16,
  parameter logic [W-1:0] RESET_VAL = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         wr_ok,
  output logic [W-1:0] limit_nxt,
  output logic [W-1:0] limit_q
);

  assign wr_ok     = wr && (wdata != '0);
  assign limit_nxt = wr_ok ? wdata : limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= RESET_VAL;
    else        limit_q <= limit_nxt;
  end

endmodule

// File: rtl/rtmo_counter.sv
module rtmo_counter
  import rx_read_timeout_pkg::*;
#(
  parameter int          W         = 16,
  parameter logic [W-1:0] RESET_VAL = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_act_e     act,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic         cnt_zero,
  output logic         expire
);

  logic [W-1:0] cnt_d;

  assign cnt_zero = (cnt_q == '0);
  assign expire   = (act == ACT_DEC) && (cnt_q == W'(1));

  always_comb begin
    unique case (act)
      ACT_RELOAD: cnt_d = reload_val;
      ACT_LOAD:   cnt_d = load_val;
      ACT_DEC:    cnt_d = cnt_q - W'(1);
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= RESET_VAL;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtmo_irq_flag.sv
module rtmo_irq_flag
  import rx_read_timeout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, set, clr);
  end

endmodule

// File: rtl/rx_read_timeout.sv
module rx_read_timeout
  import rx_read_timeout_pkg::*;
#(
  parameter int          W           = 16,
  parameter logic [W-1:0] RESET_LIMIT = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tmo_wr,
  input  logic [W-1:0] tmo_wdata,
  input  logic         rx_not_empty,
  input  logic         rx_rd,
  input  logic         card_clk_en,
  input  logic         irq_clr,
  output logic         rtout
);

  logic         wr_ok;
  logic [W-1:0] limit_nxt;
  logic [W-1:0] limit_q;
  logic [W-1:0] cnt_q;
  logic         cnt_zero;
  logic         expire;
  logic         run;
  logic         flag_clr;
  cnt_act_e     act;

  assign run      = rx_not_empty && !rx_rd;
  assign flag_clr = irq_clr || rx_rd;
  assign act      = pick_action(rx_not_empty, rx_rd, wr_ok, card_clk_en, cnt_zero);

  rtmo_limit_reg #(.W(W), .RESET_VAL(RESET_LIMIT)) u_limit (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (tmo_wr),
    .wdata     (tmo_wdata),
    .wr_ok     (wr_ok),
    .limit_nxt (limit_nxt),
    .limit_q   (limit_q)
  );

  rtmo_counter #(.W(W), .RESET_VAL(RESET_LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .reload_val (limit_nxt),
    .load_val   (tmo_wdata),
    .cnt_q      (cnt_q),
    .cnt_zero   (cnt_zero),
    .expire     (expire)
  );

  rtmo_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .clr   (flag_clr),
    .q     (rtout)
  );

endmodule

// File: rtl/rx_read_timeout_chk.sv
module rx_read_timeout_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tmo_wr,
  input logic [W-1:0] tmo_wdata,
  input logic         rx_not_empty,
  input logic         rx_rd,
  input logic         card_clk_en,
  input logic         irq_clr,
  input logic         rtout,
  input logic [W-1:0] limit_q,
  input logic [W-1:0] limit_nxt,
  input logic [W-1:0] cnt_q,
  input logic         expire,
  input logic         run
);

  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtout) |-> $past(rx_not_empty && !rx_rd && card_clk_en)); // R2

  AST_STALL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !card_clk_en && !tmo_wr) |=> $stable(cnt_q)); // R3

  AST_READ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> (cnt_q == $past(limit_nxt)) && !rtout); // R4

  AST_EMPTY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_not_empty |=> (cnt_q == $past(limit_nxt)) && !$rose(rtout)); // R5

  AST_MIDCOUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tmo_wr && tmo_wdata != '0) |=> cnt_q == $past(tmo_wdata)); // R6

  AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_wr && tmo_wdata == '0) |=> $stable(limit_q)); // R7

  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q != '0); // R7

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rtout && !irq_clr && !rx_rd) |=> rtout); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rtout); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !expire) |=> !rtout); // R8

endmodule

bind rx_read_timeout rx_read_timeout_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tmo_wr       (tmo_wr),
  .tmo_wdata    (tmo_wdata),
  .rx_not_empty (rx_not_empty),
  .rx_rd        (rx_rd),
  .card_clk_en  (card_clk_en),
  .irq_clr      (irq_clr),
  .rtout        (rtout),
  .limit_q      (limit_q),
  .limit_nxt    (limit_nxt),
  .cnt_q        (cnt_q),
  .expire       (expire),
  .run          (run)
);

// File: tb/rx_read_timeout_test.sv
`timescale 1ns/1ps
module rx_read_timeout_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmo_wr = 1'b0;
  logic [15:0] tmo_wdata = '0;
  logic        rx_not_empty = 1'b0;
  logic        rx_rd = 1'b0;
  logic        card_clk_en = 1'b0;
  logic        irq_clr = 1'b0;
  logic        rtout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_read_timeout uut (
    .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_wdata(tmo_wdata),
    .rx_not_empty(rx_not_empty), .rx_rd(rx_rd), .card_clk_en(card_clk_en),
    .irq_clr(irq_clr), .rtout(rtout)
  );

  // Behavioural reference: stored value, cycles left, interrupt level.
  int m_stored, m_left;
  bit m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stored = 200; m_left = 200; m_irq = 0;
    end else begin
      int nv;
      bit fired;
      bit wr_good;
      wr_good = tmo_wr && (tmo_wdata != 0);
      nv = wr_good ? int'(tmo_wdata) : m_stored;
      fired = 0;
      if (!rx_not_empty || rx_rd) m_left = nv;
      else if (wr_good) m_left = int'(tmo_wdata);
      else if (card_clk_en && m_left > 0) begin
        m_left = m_left - 1;
        fired = (m_left == 0);
      end
      if (fired) m_irq = 1;
      else if (irq_clr || rx_rd) m_irq = 0;
      m_stored = nv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rtout !== m_irq) begin
        errors++;
        $display("FAIL R2 model compare at %0t: actual %0b expected %0b", $time, rtout, m_irq);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input bit exp, input string req);
    checks++;
    if (rtout !== exp) begin
      errors++;
      $display("FAIL %s: rtout actual %0b expected %0b", req, rtout, exp);
    end
  endtask

  initial begin
    cyc(3);
    expect_irq(0, "R1 under reset");
    rst_n = 1'b1;
    expect_irq(0, "R1 after reset");
    // R1/R2: default value of 200 enabled clocks
    rx_not_empty = 1; card_clk_en = 1;
    cyc(199); expect_irq(0, "R1 one before expiry");
    cyc(1);   expect_irq(1, "R1 expiry at 200");
    irq_clr = 1; cyc(1); irq_clr = 0;
    expect_irq(0, "R8 clear");
    cyc(20); expect_irq(0, "R9 no refire");
    // R6: write after run-out loads the counter
    tmo_wr = 1; tmo_wdata = 5; cyc(1); tmo_wr = 0;
    cyc(4); expect_irq(0, "R6 before loaded expiry");
    cyc(1); expect_irq(1, "R6 loaded expiry");
    cyc(10); expect_irq(1, "R8 level hold");
    // R4: read reloads and clears
    card_clk_en = 0; rx_rd = 1; cyc(1); rx_rd = 0;
    expect_irq(0, "R4 read clears");
    // R3: enable every other cycle
    for (int i = 0; i < 9; i++) begin
      card_clk_en = (i % 2 == 1); cyc(1);
    end
    expect_irq(0, "R3 four enabled edges");
    card_clk_en = 1; cyc(1);
    expect_irq(1, "R3 fifth enabled edge");
    // R7: zero write mid-count
    rx_rd = 1; cyc(1); rx_rd = 0;
    cyc(2);
    tmo_wr = 1; tmo_wdata = 0; cyc(1); tmo_wr = 0;
    cyc(1); expect_irq(0, "R7 count continues");
    cyc(1); expect_irq(1, "R7 count undisturbed");
    rx_rd = 1; cyc(1); rx_rd = 0;
    cyc(4); expect_irq(0, "R7 stored value kept (before)");
    cyc(1); expect_irq(1, "R7 stored value kept");
    // R5: empty queue holds off counting
    irq_clr = 1; rx_not_empty = 0; cyc(1); irq_clr = 0;
    cyc(10); expect_irq(0, "R5 empty no count");
    tmo_wr = 1; tmo_wdata = 3; cyc(1); tmo_wr = 0;
    rx_not_empty = 1;
    cyc(2); expect_irq(0, "R6 new value before expiry");
    irq_clr = 1; cyc(1); irq_clr = 0;
    expect_irq(1, "R8 expiry beats clear");
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      rx_not_empty = ($urandom % 4) != 0;
      rx_rd        = ($urandom % 8) == 0;
      card_clk_en  = ($urandom % 3) != 0;
      irq_clr      = ($urandom % 16) == 0;
      tmo_wr       = ($urandom % 20) == 0;
      tmo_wdata    = 16'($urandom % 12);
      cyc(1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #250000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule